// File: doc/BRIEF.md
# Lane precharge pulse controller

This block produces a timed common-mode precharge pulse for the lanes of a serial display transmitter with up to four lanes. A one-cycle start strobe, together with a requested lane count, opens a pulse. The block converts the count into a mask of lower-numbered lanes. It drives that mask onto a 4-bit precharge field for a fixed interval, then returns the field to zero and reports completion with a one-cycle done pulse.

The interval is given in microseconds (`HOLD_US`, default 100). It is converted to clock cycles through `CYC_PER_US`. A lane count the transmitter does not support raises a one-cycle error pulse, and the precharge field is not driven. A strobe that arrives while a pulse is already running has no effect.

Top module: `lane_prechg_ctrl`

## Requirements
- R1: When `start` is accepted with a lane count other than 1, 2 or 4, `err` is high for exactly the next cycle. In that case `pre_o` stays 4'b0000 and `busy` stays low.
- R2: Bit i of `pre_o` belongs to lane i. The mask driven for each legal count is: count 1 gives 4'b0001, count 2 gives 4'b0011, count 4 gives 4'b1111.
- R3: For an accepted start with a legal count, the mask appears on `pre_o` in the cycle after the strobe. It stays there for exactly `HOLD_US*CYC_PER_US` cycles. After that, all four bits of `pre_o` return to zero.
- R4: `done` is high for exactly one cycle. That cycle is the first one in which `pre_o` has returned to zero after a pulse.
- R5: `busy` is high from the cycle after an accepted start through the last cycle of the hold interval. It is low in the cycle in which `done` is high.
- R6: A `start` sampled while `busy` is high is ignored. The mask, the pulse length and `err` are all unaffected, whatever `lane_cnt` holds.
- R7: Synchronous active-high `rst` leaves `pre_o` at zero and `busy`, `done` and `err` low in the following cycle. This holds even in the middle of a pulse.
- R8: While `busy` stays high, `pre_o` does not change from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| lane_cnt | input | CNT_W | Requested number of lanes |
| pre_o | output | 4 | Precharge enable, one bit per lane |
| busy | output | 1 | Pulse in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a rejected lane count |

## Verification
The assertions check the following on every cycle:
- Only a legal mask ever appears on `pre_o`.
- The mask holds steady while busy.
- An error never coincides with an active pulse.
- `done` lasts one cycle.
- `done` closes a run of exactly the hold length, measured by a counter in the checker.

Some behaviour only the bench's scenarios can show, because it depends on the value of the input at the moment of the strobe. These are:
- Which mask each count selects.
- That every illegal count in the full 3-bit range is rejected.
- That a strobe carrying a different count during a pulse leaves the pulse intact.
- That a reset in mid-pulse clears the field.

// File: rtl/lane_prechg_ctrl.sv
module lane_prechg_ctrl #(
  parameter int CYC_PER_US = 125,
  parameter int HOLD_US    = 100,
  parameter int CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] lane_cnt,
  output logic [3:0]       pre_o,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int HOLD_CYC = CYC_PER_US * HOLD_US;
  localparam int TW = $clog2(HOLD_CYC + 1);

  logic [TW-1:0] tmr;
  logic [3:0]    mask;
  logic          legal, go;

  always_comb begin
    case (lane_cnt)
      CNT_W'(1): mask = 4'b0001;
      CNT_W'(2): mask = 4'b0011;
      CNT_W'(4): mask = 4'b1111;
      default:   mask = 4'b0000;
    endcase
  end

  assign legal = |mask;
  assign go    = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_o <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      tmr   <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (go) begin
        if (legal) begin
          pre_o <= mask;
          busy  <= 1'b1;
          tmr   <= TW'(HOLD_CYC - 1);
        end else begin
          err <= 1'b1;
        end
      end else if (busy) begin
        if (tmr == '0) begin
          pre_o <= '0;
          busy  <= 1'b0;
          done  <= 1'b1;
        end else begin
          tmr <= tmr - TW'(1);
        end
      end
    end
  end
endmodule

module lpc_check #(
  parameter int HOLD_CYC = 12500
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] pre_o,
  input logic       busy,
  input logic       done,
  input logic       err
);
  int run;

  always_ff @(posedge clk) begin
    if (rst || done) run <= 0;
    else if (pre_o != 4'b0000) run <= run + 1;
  end

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (pre_o == 4'b0000 && !busy && !done && !err));

  assert_mask_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (pre_o == 4'b0000 || pre_o == 4'b0001 || pre_o == 4'b0011 || pre_o == 4'b1111));

  assert_err_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    err |-> (pre_o == 4'b0000 && !busy));

  assert_err_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  assert_hold_len_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (run == HOLD_CYC && pre_o == 4'b0000));

  assert_done_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_drop_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_mask_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> pre_o != 4'b0000);

  assert_mask_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(pre_o));
endmodule

bind lane_prechg_ctrl lpc_check #(.HOLD_CYC(CYC_PER_US * HOLD_US)) u_chk (
  .clk(clk), .rst(rst), .pre_o(pre_o), .busy(busy), .done(done), .err(err)
);

// File: tb/test_lane_prechg_ctrl.sv
module test_lane_prechg_ctrl;
  localparam int CPU  = 2;
  localparam int HUS  = 100;
  localparam int HOLD = CPU * HUS;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] lane_cnt = 3'd0;
  logic [3:0] pre_o;
  logic busy, done, err;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lane_prechg_ctrl #(.CYC_PER_US(CPU), .HOLD_US(HUS), .CNT_W(3)) i_lane_prechg_ctrl (
    .clk(clk), .rst(rst), .start(start), .lane_cnt(lane_cnt),
    .pre_o(pre_o), .busy(busy), .done(done), .err(err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_mask(input int n);
    return (n == 1 || n == 2 || n == 4) ? ((1 << n) - 1) : 0;
  endfunction

  task automatic strobe(input int n);
    @(negedge clk);
    start = 1'b1; lane_cnt = 3'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_pulse(input int n, input bit poke);
    int len;
    strobe(n);
    chk("R2 mask", pre_o, exp_mask(n));
    chk("R5 busy", busy, 1);
    len = 0;
    while (pre_o != 0 && len < HOLD + 20) begin
      chk("R8 stable", pre_o, exp_mask(n));
      len++;
      if (poke && len == 5) begin
        start = 1'b1; lane_cnt = 3'd4;
      end else if (poke && len == 6) begin
        start = 1'b1; lane_cnt = 3'd3;
      end else begin
        start = 1'b0;
      end
      if (poke) chk("R6 err", err, 0);
      @(negedge clk);
    end
    start = 1'b0;
    chk("R3 length", len, HOLD);
    chk("R3 cleared", pre_o, 0);
    chk("R4 done", done, 1);
    chk("R5 busy low", busy, 0);
    @(negedge clk);
    chk("R4 done single", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R7 reset pre", pre_o, 0);
    chk("R7 reset busy", busy, 0);
    chk("R7 reset done", done, 0);
    chk("R7 reset err", err, 0);
    for (int n = 0; n < 8; n++) begin
      if (exp_mask(n) != 0) begin
        run_pulse(n, 1'b0);
      end else begin
        strobe(n);
        chk("R1 err", err, 1);
        chk("R1 pre", pre_o, 0);
        chk("R1 busy", busy, 0);
        @(negedge clk);
        chk("R1 err single", err, 0);
        chk("R1 pre quiet", pre_o, 0);
      end
    end
    run_pulse(1, 1'b1);
    run_pulse(2, 1'b1);
    strobe(4);
    repeat (10) @(negedge clk);
    chk("R3 mid", pre_o, 15);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R7 mid pre", pre_o, 0);
    chk("R7 mid busy", busy, 0);
    repeat (HOLD) @(negedge clk);
    chk("R7 no done", done, 0);
    run_pulse(4, 1'b0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule